// File: doc/BRIEF.md
# GF(4096) Syndrome Accumulator

This block takes a codeword as a stream of 12-bit symbols, one per clock on a valid/last handshake. From it the block forms eight Reed-Solomon syndromes over GF(2^12). Each syndrome has its own accumulator, and each accumulator evaluates the received polynomial at its own root by Horner's rule. The first symbol of the stream is the highest-order coefficient. The field arithmetic uses a composite representation: a 12-bit element is a pair of GF(2^6) halves, and the product is formed from four small base-field multipliers.

The roots are successive powers of a generator element. The first root is 1, the next is the generator, and so on. A downstream error locator reads the syndromes as four 32-bit words, two syndromes per word. A flag reports that the codeword just completed has a nonzero syndrome. A clear input starts a new codeword. The clear may coincide with the codeword's first symbol.

Top module: `gf_syndrome_unit`

## Requirements
- R1: Base-field multiplication works over GF(2^6) modulo x^6+x+1. When shift-and-add moves a term out of bit 5, the operand is reduced by XOR with 0x03 on the low six bits (that is, 0x43 on seven bits).
- R2: A 12-bit element is {hi[5:0] at bits 11:6, lo[5:0] at bits 5:0}. The product's high half is m(ah^al, bh^bl)^m(al,bl). The product's low half is m(m(ah,bh),0x21)^m(al,bl).
- R3: Root i is found by applying a step i+1 times, starting from zero. The step maps zero to 1 and maps any other x to x times the generator 0xE01. So root 0 is 1 and root 1 is 0xE01.
- R4: On a cycle with in_valid high and clr low, each accumulator becomes S_i*root_i XOR in_sym.
- R5: A cycle with clr high and in_valid low sets every accumulator to zero.
- R6: A cycle with clr and in_valid both high loads in_sym into every accumulator. The earlier accumulated value has no effect.
- R7: A cycle with in_valid and clr both low leaves every accumulator unchanged.
- R8: syn_valid rises in the cycle after a symbol with in_last high. It then holds through idle cycles. It falls after a clr or after a valid symbol without in_last. It is low after reset.
- R9: Word k of syn_words (bits 32k+31:32k) carries syndrome 2k in bits 11:0 and syndrome 2k+1 in bits 27:16. All other bits are zero.
- R10: syn_nonzero is high exactly when syn_valid is high and at least one syndrome is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Start a new codeword |
| in_valid | input | 1 | in_sym carries a symbol this cycle |
| in_last | input | 1 | This symbol ends the codeword |
| in_sym | input | 12 | Received symbol |
| syn_words | output | 128 | Four packed syndrome words |
| syn_valid | output | 1 | Syndromes describe a completed codeword |
| syn_nonzero | output | 1 | Completed codeword has a nonzero syndrome |

## Verification
A clear and a symbol can arrive in the same cycle. The clear then has to discard the previous codeword's state, while the symbol still has to enter as the first coefficient. The bench provokes this by letting one codeword leave nonzero accumulators, then sending the next codeword's first symbol together with clr. The resulting syndromes must equal those of the new codeword alone, which the bench computes by direct polynomial evaluation. A separate clear without a symbol must leave all words at zero and drop syn_valid.

// File: rtl/gfsyn_pkg.sv
package gfsyn_pkg;
   localparam int HALF_W = 6;
   localparam int FULL_W = 2 * HALF_W;

   function automatic logic [HALF_W-1:0] base_mul(input logic [HALF_W-1:0] a,
                                                   input logic [HALF_W-1:0] b);
      logic [HALF_W-1:0] acc;
      logic [HALF_W-1:0] sh;
      acc = '0;
      sh  = b;
      for (int k = 0; k < HALF_W; k++) begin
         if (a[k]) acc ^= sh;
         sh = {sh[HALF_W-2:0], 1'b0} ^ (sh[HALF_W-1] ? 6'h03 : 6'h00);
      end
      return acc;
   endfunction

   function automatic logic [FULL_W-1:0] tower_mul(input logic [FULL_W-1:0] a,
                                                    input logic [FULL_W-1:0] b);
      logic [HALF_W-1:0] ah, al, bh, bl, ll;
      ah = a[FULL_W-1:HALF_W]; al = a[HALF_W-1:0];
      bh = b[FULL_W-1:HALF_W]; bl = b[HALF_W-1:0];
      ll = base_mul(al, bl);
      return {base_mul(ah ^ al, bh ^ bl) ^ ll,
              base_mul(base_mul(ah, bh), 6'h21) ^ ll};
   endfunction

   function automatic logic [FULL_W-1:0] root_of(input int idx,
                                                  input logic [FULL_W-1:0] gen);
      logic [FULL_W-1:0] r;
      r = '0;
      for (int k = 0; k <= idx; k++)
         r = (r == '0) ? {{(FULL_W-1){1'b0}}, 1'b1} : tower_mul(r, gen);
      return r;
   endfunction
endpackage

// File: rtl/gf_base_mul.sv
module gf_base_mul #(
   parameter int W = 6
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] p_o
);
   logic [W-1:0] part [W+1];
   logic [W-1:0] shv  [W+1];

   assign part[0] = '0;
   assign shv[0]  = b_i;

   for (genvar k = 0; k < W; k++) begin : g_step
      // R1: shift-and-add with reduction by x^6 = x + 1
      assign part[k+1] = part[k] ^ (a_i[k] ? shv[k] : '0);
      assign shv[k+1]  = {shv[k][W-2:0], 1'b0} ^ (shv[k][W-1] ? W'(3) : '0);
   end

   assign p_o = part[W];

   if (W != 6) begin : g_bad_w
      $error("gf_base_mul: reduction constant fixed for W=6");
   end
endmodule

// File: rtl/gf_tower_mul.sv
module gf_tower_mul #(
   parameter int HW = 6
) (
   input  logic [2*HW-1:0] a_i,
   input  logic [2*HW-1:0] b_i,
   output logic [2*HW-1:0] p_o
);
   localparam logic [HW-1:0] NORM_K = HW'(6'h21);

   logic [HW-1:0] ah, al, bh, bl;
   logic [HW-1:0] p_hh, p_ll, p_mix, p_sc;

   assign ah = a_i[2*HW-1:HW];
   assign al = a_i[HW-1:0];
   assign bh = b_i[2*HW-1:HW];
   assign bl = b_i[HW-1:0];

   gf_base_mul #(.W(HW)) u_hh  (.a_i(ah),      .b_i(bh),      .p_o(p_hh));
   gf_base_mul #(.W(HW)) u_ll  (.a_i(al),      .b_i(bl),      .p_o(p_ll));
   gf_base_mul #(.W(HW)) u_mix (.a_i(ah ^ al), .b_i(bh ^ bl), .p_o(p_mix));
   gf_base_mul #(.W(HW)) u_sc  (.a_i(p_hh),    .b_i(NORM_K),  .p_o(p_sc));

   // R2: composite-field product
   assign p_o = {p_mix ^ p_ll, p_sc ^ p_ll};
endmodule

// File: rtl/gf_syn_cell.sv
module gf_syn_cell #(
   parameter int          SYM_W = 12,
   parameter logic [11:0] ROOT  = 12'h001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             in_valid,
   input  logic [SYM_W-1:0] in_sym,
   output logic [SYM_W-1:0] acc_q
);
   localparam int HW = SYM_W / 2;

   logic [SYM_W-1:0] scaled;
   logic [SYM_W-1:0] acc_d;

   if (ROOT == 12'h001) begin : g_unit
      assign scaled = acc_q;
   end else begin : g_tower
      gf_tower_mul #(.HW(HW)) u_mul (.a_i(acc_q), .b_i(ROOT), .p_o(scaled));
   end

   always_comb begin
      if (clr)           acc_d = in_valid ? in_sym : '0;
      else if (in_valid) acc_d = scaled ^ in_sym;   // R4
      else               acc_d = acc_q;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !in_valid |=> acc_q == '0);                          // R5
   AST_CLR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      clr && in_valid |=> acc_q == $past(in_sym));                // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && !in_valid |=> $stable(acc_q));                      // R7
endmodule

// File: rtl/gf_syndrome_unit.sv
module gf_syndrome_unit #(
   parameter int          SYM_W      = 12,
   parameter int          NUM_SYN    = 8,
   parameter int          WORD_W     = 32,
   parameter logic [11:0] GEN        = 12'hE01,
   parameter int          FIRST_ROOT = 0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clr,
   input  logic                              in_valid,
   input  logic                              in_last,
   input  logic [SYM_W-1:0]                  in_sym,
   output logic [(NUM_SYN/2)*WORD_W-1:0]     syn_words,
   output logic                              syn_valid,
   output logic                              syn_nonzero
);
   import gfsyn_pkg::*;

   localparam int NUM_WORDS = NUM_SYN / 2;
   localparam int SLOT      = WORD_W / 2;
   localparam int PAD       = SLOT - SYM_W;

   if (SYM_W != FULL_W) begin : g_bad_sym
      $error("gf_syndrome_unit: SYM_W must be 12 for the tower field");
   end
   if (NUM_SYN % 2 != 0) begin : g_bad_cnt
      $error("gf_syndrome_unit: NUM_SYN must be even");
   end
   if (PAD < 0) begin : g_bad_word
      $error("gf_syndrome_unit: WORD_W too narrow for two symbols");
   end

   logic [SYM_W-1:0] acc [NUM_SYN];

   for (genvar i = 0; i < NUM_SYN; i++) begin : g_cell
      localparam logic [11:0] ROOT_I = root_of(FIRST_ROOT + i, GEN);   // R3
      gf_syn_cell #(.SYM_W(SYM_W), .ROOT(ROOT_I)) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr),
         .in_valid(in_valid),
         .in_sym  (in_sym),
         .acc_q   (acc[i])
      );
   end

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_pack
      // R9: even index low slot, odd index high slot
      assign syn_words[w*WORD_W +: WORD_W] =
         {{PAD{1'b0}}, acc[2*w+1], {PAD{1'b0}}, acc[2*w]};
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                    syn_valid <= 1'b0;
      else if (clr || in_valid)      syn_valid <= in_valid && in_last;

   logic any_set;
   always_comb begin
      any_set = 1'b0;
      for (int i = 0; i < NUM_SYN; i++) any_set |= (acc[i] != '0);
   end

   assign syn_nonzero = syn_valid && any_set;   // R10

   AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_last |=> syn_valid);                            // R8
   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (clr || in_valid) && !(in_valid && in_last) |=> !syn_valid);   // R8
   AST_FLAG_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      syn_nonzero |-> syn_valid);                                    // R10
endmodule

// File: tb/test_gf_syndrome_unit.sv
module test_gf_syndrome_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clr = 1'b0, in_valid = 1'b0, in_last = 1'b0;
   logic [11:0]  in_sym = '0;
   logic [127:0] syn_words;
   logic         syn_valid, syn_nonzero;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   gf_syndrome_unit i_gf_syndrome_unit (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
      .in_last(in_last), .in_sym(in_sym), .syn_words(syn_words),
      .syn_valid(syn_valid), .syn_nonzero(syn_nonzero));

   // polynomial product then fold bits 10..6 back with x^6 = x + 1 (R1)
   function automatic logic [5:0] m64(input logic [5:0] a, input logic [5:0] b);
      logic [10:0] p = '0;
      for (int k = 0; k < 6; k++) if (b[k]) p ^= 11'(a) << k;
      for (int k = 10; k >= 6; k--) if (p[k]) p ^= 11'h43 << (k - 6);
      return p[5:0];
   endfunction

   function automatic logic [11:0] m12(input logic [11:0] a, input logic [11:0] b);
      logic [5:0] lo_prod = m64(a[5:0], b[5:0]);
      return {m64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ lo_prod,
              m64(m64(a[11:6], b[11:6]), 6'h21) ^ lo_prod};   // R2
   endfunction

   function automatic logic [11:0] pw(input logic [11:0] x, input int e);
      logic [11:0] r = 12'h001;
      for (int k = 0; k < e; k++) r = m12(r, x);
      return r;
   endfunction

   logic [11:0] root [8];
   logic [11:0] cw [16];
   int          cw_n;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   // direct evaluation: sum of c_j * r^(n-1-j)
   task automatic check_cw(input string req);
      logic [11:0] s [8];
      for (int i = 0; i < 8; i++) begin
         s[i] = '0;
         for (int j = 0; j < cw_n; j++) s[i] ^= m12(cw[j], pw(root[i], cw_n - 1 - j));
      end
      for (int w = 0; w < 4; w++)
         chk(req, syn_words[32*w +: 32], {4'h0, s[2*w+1], 4'h0, s[2*w]});
   endtask

   task automatic put(input logic [11:0] s, input bit c, input bit l);
      @(negedge clk); clr = c; in_valid = 1'b1; in_sym = s; in_last = l;
   endtask

   task automatic idle();
      @(negedge clk); clr = 1'b0; in_valid = 1'b0; in_last = 1'b0;
   endtask

   initial begin
      #1ms;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      root[0] = 12'h001;
      for (int i = 1; i < 8; i++) root[i] = m12(root[i-1], 12'hE01);
      repeat (3) @(negedge clk);
      // reset state (R8, R9, R10)
      chk("R8 reset", {31'd0, syn_valid}, 32'd0);
      chk("R9 reset", syn_words[31:0] | syn_words[127:96], 32'd0);
      chk("R10 reset", {31'd0, syn_nonzero}, 32'd0);
      rst_n = 1'b1;
      idle();

      // R3: single-symbol 1 followed by 0 exposes the roots themselves
      put(12'h001, 1, 0); put(12'h000, 0, 1); idle();
      chk("R3 root0", {20'd0, syn_words[11:0]}, 32'h001);
      chk("R3 root1", {20'd0, syn_words[27:16]}, 32'hE01);

      // sweep: codeword [a, 0] gives a*root_i for every a (R1, R2, R4, R10)
      for (int a = 0; a < 4096; a++) begin
         put(12'(a), 1, 0); put(12'h000, 0, 1); idle();
         cw[0] = 12'(a); cw[1] = 12'h000; cw_n = 2;
         check_cw("R1 R2 R4 sweep");
         chk("R10 sweep", {31'd0, syn_nonzero}, {31'd0, a != 0});
      end

      // multi-symbol codeword with idle gaps (R7) and syn_valid timing (R8)
      cw_n = 6;
      for (int j = 0; j < 6; j++) cw[j] = 12'(37 * j * j + 5 * j + 11);
      put(cw[0], 1, 0);
      for (int j = 1; j < 6; j++) begin
         idle(); idle();
         chk("R8 mid", {31'd0, syn_valid}, 32'd0);
         if (j < 5) put(cw[j], 0, 0); else put(cw[j], 0, 1);
      end
      idle();
      chk("R8 rise", {31'd0, syn_valid}, 32'd1);
      check_cw("R7 gaps");
      chk("R9 pad", syn_words[31:0] & 32'hF000F000, 32'd0);
      repeat (3) idle();
      chk("R8 hold", {31'd0, syn_valid}, 32'd1);
      check_cw("R7 hold");

      // clear with first symbol over nonzero state (R6)
      cw_n = 3; cw[0] = 12'hABC; cw[1] = 12'h123; cw[2] = 12'hFFF;
      put(cw[0], 1, 0);
      idle();
      chk("R8 fall", {31'd0, syn_valid}, 32'd0);
      put(cw[1], 0, 0); put(cw[2], 0, 1); idle();
      check_cw("R6 clr+valid");

      // non-last symbol drops syn_valid (R8)
      put(12'h055, 0, 0); idle();
      chk("R8 drop", {31'd0, syn_valid}, 32'd0);

      // clear alone (R5)
      @(negedge clk); clr = 1'b1; in_valid = 1'b0;
      idle();
      for (int w = 0; w < 4; w++) chk("R5 clear", syn_words[32*w +: 32], 32'd0);
      chk("R5 valid", {31'd0, syn_valid}, 32'd0);
      chk("R10 clear", {31'd0, syn_nonzero}, 32'd0);

      // single symbol after clear: every syndrome equals the symbol (R4)
      put(12'h9A5, 0, 1); idle();
      cw_n = 1; cw[0] = 12'h9A5;
      check_cw("R4 single");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule